// File: doc/BRIEF.md
# First-Fault Vector Load Unit

This block carries out one vector load in first-faulting mode. A start pulse captures a base address and a governing predicate with one bit per element. The unit then walks the active elements from the lowest index upward and issues one address request per active element. Each request is answered by a response that carries either data or a fault indication. Good data is written into the matching slot of a destination register that persists across loads. Inactive elements are skipped entirely: they are never requested and their destination slots are never written.

Faults are handled in two ways. A fault on the first active element is a real trap. The trap output pulses, nothing is written, and the first-fault predicate stays all ones. A fault on any later active element is swallowed. The load stops at that element, and the first-fault predicate is cleared from that element upward. Software reads the predicate to learn how many leading elements hold valid data. Elements loaded before the stop keep their new data. Elements at and beyond the stop keep whatever they held before. A single-cycle done pulse marks the end of every load.

Top module: `ffload_unit`

## Requirements
- R1: A start pulse while idle captures the base address and the governing predicate, sets the first-fault predicate to all ones, and requests the active elements strictly in ascending index order, one per response. Each request carries address base + index × ELEM_BYTES and the element index.
- R2: Elements whose governing predicate bit is 0 are never requested, and their destination slots keep their previous contents. A fault that the response source would give for such an element therefore has no effect.
- R3: A response without a fault writes its data into destination slot `index`, which occupies bits index×DATA_W upward of `dest_o`.
- R4: A fault on the first active element of a load raises `trap_o` for exactly one cycle. The first-fault predicate stays all ones and no destination slot changes.
- R5: A fault on a later active element raises no trap and ends the load there. The first-fault predicate keeps its bits below the faulting index and clears that bit and every bit above it. With 8 elements, a fault on element 5 gives 8'b0001_1111.
- R6: After a suppressed fault, slots below the fault hold the newly loaded data. Slots at and above the fault keep their previous contents, and no request is made past the faulting element.
- R7: `done_o` is high for exactly one cycle: the cycle after the last active element's response, or after the response that stops the load. With an empty predicate it is high in the cycle after the start pulse, and the first-fault predicate is all ones.
- R8: A start pulse while a load is in progress is ignored. The running load keeps its base address, its predicate and its request sequence.
- R9: After reset the unit is idle with no request, no trap, no done, the first-fault predicate all ones and every destination slot zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a first-faulting load (sampled while idle) |
| base_addr_i | input | ADDR_W | Address of element 0 |
| gov_pred_i | input | NUM_ELEM | Governing predicate, bit i enables element i |
| req_valid_o | output | 1 | An element request is outstanding |
| req_addr_o | output | ADDR_W | Address of the requested element |
| req_idx_o | output | IDX_W | Index of the requested element |
| rsp_valid_i | input | 1 | Response for the outstanding request |
| rsp_fault_i | input | 1 | The response reports a fault |
| rsp_data_i | input | DATA_W | Loaded data when no fault |
| dest_o | output | NUM_ELEM×DATA_W | Destination register, slot i at bits i×DATA_W |
| ffr_o | output | NUM_ELEM | First-fault predicate |
| trap_o | output | 1 | One-cycle trap pulse for a fault on the first active element |
| done_o | output | 1 | One-cycle end-of-load pulse |
| busy_o | output | 1 | A load is in progress |

## Verification
The bound checker watches the invariants that hold on every cycle. The first-fault predicate is all ones while any request is outstanding and never regains a cleared bit during a load. A trap only comes together with done and leaves the predicate all ones. Done is a lone pulse outside the busy window, and an accepted start always leaves the predicate all ones. Other behaviour depends on a complete load, so only the bench's scenarios can show it. These include the exact request order and addresses, the split between trapping and suppressed faults as the predicate changes, which destination slots change and which keep their old data, the predicate value after a suppressed fault, and a start pulse being ignored mid-load.

// File: rtl/ffl_pkg.sv
package ffl_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ffl_state_e;
endpackage

// File: rtl/ffl_next_active.sv
// Finds the lowest set predicate bit at or above a starting index.
module ffl_next_active #(
    parameter int NUM_ELEM = 8,
    parameter int IDX_W    = 3,
    parameter int CNT_W    = 4
) (
    input  logic [NUM_ELEM-1:0] pred_i,
    input  logic [CNT_W-1:0]    from_i,
    output logic                found_o,
    output logic [IDX_W-1:0]    idx_o
);
    logic [NUM_ELEM-1:0] cand;

    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_cand
        assign cand[g] = pred_i[g] && (CNT_W'(g) >= from_i);
    end

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_ELEM - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ffl_below_mask.sv
// Produces a mask with every bit strictly below the given index set.
module ffl_below_mask #(
    parameter int NUM_ELEM = 8,
    parameter int IDX_W    = 3
) (
    input  logic [IDX_W-1:0]    idx_i,
    output logic [NUM_ELEM-1:0] mask_o
);
    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_mask
        assign mask_o[g] = (IDX_W'(g) < idx_i);
    end
endmodule

// File: rtl/ffload_unit.sv
module ffload_unit #(
    parameter int NUM_ELEM   = 8,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int ELEM_BYTES = 4,
    localparam int IDX_W     = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1,
    localparam int CNT_W     = $clog2(NUM_ELEM + 1) + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [ADDR_W-1:0]            base_addr_i,
    input  logic [NUM_ELEM-1:0]          gov_pred_i,
    output logic                         req_valid_o,
    output logic [ADDR_W-1:0]            req_addr_o,
    output logic [IDX_W-1:0]             req_idx_o,
    input  logic                         rsp_valid_i,
    input  logic                         rsp_fault_i,
    input  logic [DATA_W-1:0]            rsp_data_i,
    output logic [NUM_ELEM*DATA_W-1:0]   dest_o,
    output logic [NUM_ELEM-1:0]          ffr_o,
    output logic                         trap_o,
    output logic                         done_o,
    output logic                         busy_o
);
    import ffl_pkg::*;

    typedef struct packed {
        ffl_state_e                       st;
        logic [IDX_W-1:0]                 idx;
        logic [ADDR_W-1:0]                base;
        logic [NUM_ELEM-1:0]              pred;
        logic                             seen;
        logic [NUM_ELEM-1:0]              ffr;
        logic [NUM_ELEM-1:0][DATA_W-1:0]  dest;
        logic                             trap;
        logic                             done;
    } ffl_regs_t;

    localparam ffl_regs_t REGS_RST = '{
        st:   ST_IDLE,
        idx:  '0,
        base: '0,
        pred: '0,
        seen: 1'b0,
        ffr:  '1,
        dest: '0,
        trap: 1'b0,
        done: 1'b0
    };

    ffl_regs_t regs_q, regs_d;

    logic                first_found, next_found;
    logic [IDX_W-1:0]    first_idx, next_idx;
    logic [CNT_W-1:0]    next_from;
    logic [NUM_ELEM-1:0] keep_mask;

    assign next_from = CNT_W'(regs_q.idx) + CNT_W'(1);

    ffl_next_active #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_first (
        .pred_i  (gov_pred_i),
        .from_i  ('0),
        .found_o (first_found),
        .idx_o   (first_idx)
    );

    ffl_next_active #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_next (
        .pred_i  (regs_q.pred),
        .from_i  (next_from),
        .found_o (next_found),
        .idx_o   (next_idx)
    );

    ffl_below_mask #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W)) u_keep (
        .idx_i  (regs_q.idx),
        .mask_o (keep_mask)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.trap = 1'b0;
        regs_d.done = 1'b0;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    regs_d.ffr  = '1;
                    regs_d.pred = gov_pred_i;
                    regs_d.base = base_addr_i;
                    regs_d.seen = 1'b0;
                    if (first_found) begin
                        regs_d.st  = ST_RUN;
                        regs_d.idx = first_idx;
                    end else begin
                        regs_d.done = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (rsp_valid_i) begin
                    if (rsp_fault_i) begin
                        regs_d.st   = ST_IDLE;
                        regs_d.done = 1'b1;
                        if (!regs_q.seen) begin
                            regs_d.trap = 1'b1;
                        end else begin
                            regs_d.ffr = regs_q.ffr & keep_mask;
                        end
                    end else begin
                        regs_d.dest[regs_q.idx] = rsp_data_i;
                        regs_d.seen             = 1'b1;
                        if (next_found) begin
                            regs_d.idx = next_idx;
                        end else begin
                            regs_d.st   = ST_IDLE;
                            regs_d.done = 1'b1;
                        end
                    end
                end
            end
            default: regs_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= REGS_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign busy_o      = (regs_q.st == ST_RUN);
    assign req_valid_o = (regs_q.st == ST_RUN);
    assign req_idx_o   = regs_q.idx;
    assign req_addr_o  = regs_q.base + ADDR_W'(regs_q.idx) * ADDR_W'(ELEM_BYTES);
    assign dest_o      = regs_q.dest;
    assign ffr_o       = regs_q.ffr;
    assign trap_o      = regs_q.trap;
    assign done_o      = regs_q.done;
endmodule

// File: rtl/ffl_checker.sv
module ffl_checker #(
    parameter int NUM_ELEM = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                req_valid_o,
    input logic [NUM_ELEM-1:0] ffr_o,
    input logic                trap_o,
    input logic                done_o,
    input logic                busy_o
);
    // R4
    trap_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> done_o);

    // R4
    trap_keeps_ffr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (ffr_o == '1));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R5
    ffr_full_while_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (ffr_o == '1));

    // R1
    start_sets_ffr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (ffr_o == '1));

    // R5
    ffr_no_regrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ((ffr_o & ~$past(ffr_o)) == '0));
endmodule

bind ffload_unit ffl_checker #(.NUM_ELEM(NUM_ELEM)) u_ffl_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .req_valid_o (req_valid_o),
    .ffr_o       (ffr_o),
    .trap_o      (trap_o),
    .done_o      (done_o),
    .busy_o      (busy_o)
);

// File: tb/ffload_unit_bench.sv
module ffload_unit_bench;
    localparam int NE = 8;
    localparam int DW = 32;
    localparam int AW = 32;
    localparam int EB = 4;
    localparam int NV = 7;

    localparam logic [NE-1:0] V_PRED  [NV] = '{8'hFF, 8'h55, 8'hFF, 8'hF0, 8'hA6, 8'h0F, 8'h81};
    localparam logic [NE-1:0] V_FAULT [NV] = '{8'h00, 8'h00, 8'h20, 8'h10, 8'h20, 8'hF0, 8'h80};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [AW-1:0] base_addr_i = '0;
    logic [NE-1:0] gov_pred_i = '0;
    logic req_valid_o;
    logic [AW-1:0] req_addr_o;
    logic [2:0] req_idx_o;
    logic rsp_valid_i = 1'b0;
    logic rsp_fault_i = 1'b0;
    logic [DW-1:0] rsp_data_i = '0;
    logic [NE*DW-1:0] dest_o;
    logic [NE-1:0] ffr_o;
    logic trap_o, done_o, busy_o;

    int n_tests = 0;
    int n_fail = 0;
    logic [NE-1:0][DW-1:0] model_dest = '0;

    always #10ns clk = ~clk;

    ffload_unit #(.NUM_ELEM(NE), .DATA_W(DW), .ADDR_W(AW), .ELEM_BYTES(EB)) u_ffload_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
        .gov_pred_i(gov_pred_i), .req_valid_o(req_valid_o), .req_addr_o(req_addr_o),
        .req_idx_o(req_idx_o), .rsp_valid_i(rsp_valid_i), .rsp_fault_i(rsp_fault_i),
        .rsp_data_i(rsp_data_i), .dest_o(dest_o), .ffr_o(ffr_o), .trap_o(trap_o),
        .done_o(done_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [NE*DW-1:0] act, input logic [NE*DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] elem_data(input logic [7:0] tag, input int i);
        return {tag, 8'h5A, 8'h00, 8'(i)};
    endfunction

    task automatic run_load(input logic [NE-1:0] pred, input logic [NE-1:0] fmask,
                            input logic [AW-1:0] base, input logic [7:0] tag,
                            input bit poke, input string rq);
        int seq [NE];
        int nseq = 0;
        int nreq = 0;
        int cyc = 0;
        bit first = 1'b1;
        bit stop = 1'b0;
        bit exp_trap = 1'b0;
        bit got_trap = 1'b0;
        bit order_ok = 1'b1;
        logic [NE-1:0] exp_ffr = '1;
        for (int i = 0; i < NE; i++) begin
            if (!stop && pred[i]) begin
                seq[nseq] = i;
                nseq++;
                if (fmask[i]) begin
                    if (first) exp_trap = 1'b1;
                    else for (int j = i; j < NE; j++) exp_ffr[j] = 1'b0;
                    stop = 1'b1;
                end else begin
                    model_dest[i] = elem_data(tag, i);
                    first = 1'b0;
                end
            end
        end
        @(negedge clk);
        start_i = 1'b1; base_addr_i = base; gov_pred_i = pred;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && cyc < 40) begin
            if (req_valid_o) begin
                if (nreq >= nseq || int'(req_idx_o) != seq[nreq] ||
                    req_addr_o != base + AW'(int'(req_idx_o) * EB))
                    order_ok = 1'b0;
                rsp_valid_i = 1'b1;
                rsp_fault_i = fmask[req_idx_o];
                rsp_data_i  = elem_data(tag, int'(req_idx_o));
                nreq++;
            end else begin
                rsp_valid_i = 1'b0;
            end
            if (poke && nreq == 2) begin
                start_i = 1'b1; base_addr_i = ~base; gov_pred_i = '1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        rsp_valid_i = 1'b0;
        start_i = 1'b0;
        got_trap = trap_o;
        chk(done_o, "R7", {rq, " done seen"}, done_o, 1);
        chk(order_ok && nreq == nseq, "R1", {rq, " request order/address/count"}, nreq, nseq);
        chk(got_trap == exp_trap, exp_trap ? "R4" : "R5", {rq, " trap"}, got_trap, exp_trap);
        chk(ffr_o == exp_ffr, "R5", {rq, " ffr"}, ffr_o, exp_ffr);
        chk(dest_o == model_dest, "R6", {rq, " destination (R2 R3)"}, dest_o, model_dest);
        @(negedge clk);
        chk(!done_o && !trap_o, "R7", {rq, " done/trap pulse width"}, {done_o, trap_o}, 0);
    endtask

    initial begin
        #(20ns * 150000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!busy_o && !req_valid_o && !done_o && !trap_o, "R9", "idle outputs",
            {busy_o, req_valid_o, done_o, trap_o}, 0);
        chk(ffr_o == '1, "R9", "ffr in reset", ffr_o, 8'hFF);
        chk(dest_o == '0, "R9", "dest in reset", dest_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ffr_o == '1 && dest_o == '0, "R9", "state after reset release", ffr_o, 8'hFF);

        // vector table: R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            run_load(V_PRED[v], V_FAULT[v], 32'h1000_0000 + AW'(v * 256), 8'(8'h10 + v), 1'b0,
                     $sformatf("vec%0d", v));
        end

        // R7 empty predicate: done right after start
        @(negedge clk);
        start_i = 1'b1; gov_pred_i = '0; base_addr_i = 32'h2000;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o && !busy_o && !req_valid_o, "R7", "empty predicate done", {done_o, busy_o}, 2'b10);
        chk(ffr_o == '1, "R7", "empty predicate ffr", ffr_o, 8'hFF);
        @(negedge clk);
        chk(!done_o, "R7", "empty predicate done width", done_o, 0);

        // R8 start during a load is ignored
        run_load(8'hFF, 8'h00, 32'h3000_0040, 8'hC3, 1'b1, "R8 start while busy");

        // R5 suppressed fault on element 1 after element 0 loaded
        run_load(8'h03, 8'h02, 32'h4000_0000, 8'hE1, 1'b0, "R5 fault at 1");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule